// File: doc/BRIEF.md
# GPIO Bank Controller with Per-Pin Interrupts

This block is a register-mapped general-purpose I/O controller for up to 40 pins, grouped into a full 32-bit bank and a narrower upper bank. Software drives the pins through an output register per bank. The output register accepts a plain load, and it also accepts atomic set-mask and clear-mask writes, so two agents can touch different pins without a read-modify-write race. Software reads the synchronized pin levels through an input register.

Each pin has its own configuration word with three fields. A trigger code selects what the pin detects. A routing field holds the interrupt enable bits. An inversion bit flips the pin before both the input register and the detector. The detector marks an event in a per-bank status register, and software acknowledges events by writing ones to a clear-mask alias of that register. One interrupt line toward the CPU is raised while any routed status bit is set, in either bank.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the outputs, every status bit, every configuration word and the interrupt line all read 0.
- R2: Byte offsets within a bank window are: 0x00 output (load), 0x04 set-mask, 0x08 clear-mask, 0x0C input, 0x10 status, 0x14 status clear-mask. A load replaces the whole output register. A set-mask or clear-mask write changes only the bits written as 1 and leaves the other output bits unchanged.
- R3: Bank 0 is at 0x000 and covers pins 0 to 31. Bank 1 is at 0x020, and its bit 0 is pin 32. Mask bits above the bank width are ignored.
- R4: The input register returns each pin's level after a two-flop synchronizer. A change on a pin is readable two clock edges after it is applied.
- R5: The configuration word of pin n is at 0x100 + 4*n. Bits [2:0] hold the trigger code: 0 off, 1 rising, 2 falling, 3 either edge, 4 low level, 5 high level. Codes 6 and 7 act as off and never set a status bit.
- R6: An edge trigger sets the pin's status bit one edge after the synchronized edge is seen. The bit then stays set after the pin returns.
- R7: A level trigger sets the status bit on every cycle in which the active level is present, so a clear issued while that level persists leaves the bit set.
- R8: A write to a status clear-mask clears exactly the bits written as 1 in that bank. Other bits and the other bank are unchanged.
- R9: Bits [7:3] of a configuration word form the routing field, and bit 5 (routing bit 2) enables the pin toward the CPU. cpu_irq is high exactly when some status bit of a pin with bit 5 set is 1.
- R10: When a detected event and a clear-mask write hit the same status bit in the same cycle, the bit ends up set.
- R11: Bit 8 of a configuration word inverts the pin before the input register and before the detector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NPINS | Raw pin levels |
| pin_out | output | NPINS | Driven pin values |
| cpu_irq | output | 1 | Combined interrupt toward the CPU |

## Verification
The detector is exercised one trigger code at a time, each with both directions of pin motion. The falling code must ignore a rise. The either-edge code must latch on both. The invalid code must latch on nothing.

The level codes are paired with a clear issued while the level persists and with a clear issued after it drops. Only the second clear may take effect, which separates level triggering from edge triggering.

A fall on a pin is timed to meet a status clear in the same cycle, which tells set-priority apart from clear-priority. A pin that latches with routing disabled separates the status bit from the interrupt line. An inverted pin latches on its physical fall, which shows that the inversion sits in front of the detector.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int BANK_BITS = 32;

  // register offsets inside one bank window
  localparam logic [4:0] OFS_OUT = 5'h00;
  localparam logic [4:0] OFS_SET = 5'h04;
  localparam logic [4:0] OFS_CLR = 5'h08;
  localparam logic [4:0] OFS_IN  = 5'h0C;
  localparam logic [4:0] OFS_ST  = 5'h10;
  localparam logic [4:0] OFS_STC = 5'h14;

  localparam int CFG_PAGE = 1;   // address bits above 8 select the config page
  localparam int CPU0_BIT = 2;   // routing bit that targets the CPU

  typedef enum logic [2:0] {
    TRIG_OFF  = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_ANY  = 3'd3,
    TRIG_LOW  = 3'd4,
    TRIG_HIGH = 3'd5
  } trig_e;

  typedef struct packed {
    logic       inv;
    logic [4:0] route;
    logic [2:0] trig;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_pin_detect.sv
`timescale 1ns/1ps
module gpio_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic [2:0] trig,
  output logic       evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  always_comb begin
    case (trig)
      TRIG_RISE: evt = lvl & ~prev_q;
      TRIG_FALL: evt = ~lvl & prev_q;
      TRIG_ANY:  evt = lvl ^ prev_q;
      TRIG_LOW:  evt = ~lvl;
      TRIG_HIGH: evt = lvl;
      default:   evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs #(
  parameter int BW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_out,
  input  logic          we_set,
  input  logic          we_clr,
  input  logic          we_stc,
  input  logic [BW-1:0] wdata,
  input  logic [BW-1:0] evt,
  output logic [BW-1:0] out_q,
  output logic [BW-1:0] stat_q
);
  logic [BW-1:0] out_d;
  logic [BW-1:0] stat_d;
  logic          out_en;

  always_comb begin
    out_en = we_out | we_set | we_clr;
    out_d  = out_q;
    if (we_out)      out_d = wdata;
    else if (we_set) out_d = out_q | wdata;
    else if (we_clr) out_d = out_q & ~wdata;
    // an event in the same cycle as a clear keeps the bit set
    stat_d = (stat_q & ~(we_stc ? wdata : '0)) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      stat_q <= '0;
    end else begin
      if (out_en) out_q <= out_d;
      stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 40,
  parameter int ADDR_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BANK_BITS-1:0] bus_wdata,
  output logic [BANK_BITS-1:0] bus_rdata,
  input  logic [NPINS-1:0]     pin_in,
  output logic [NPINS-1:0]     pin_out,
  output logic                 cpu_irq
);
  localparam int NBANK = (NPINS + BANK_BITS - 1) / BANK_BITS;
  localparam int PADW  = NBANK * BANK_BITS;
  localparam int CFG_W = $bits(pin_cfg_t);
  localparam logic [ADDR_W-9:0] CFG_PAGE_V = (ADDR_W-8)'(CFG_PAGE);

  // reset: asserted asynchronously, released through two flops
  logic rst_m_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_n <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_m_n <= 1'b1;
      rst_q_n <= rst_m_n;
    end
  end

  // address fields
  logic [ADDR_W-9:0] page;
  logic [2:0]        bsel;
  logic [4:0]        ofs;
  logic [5:0]        cidx;
  assign page = bus_addr[ADDR_W-1:8];
  assign bsel = bus_addr[7:5];
  assign ofs  = bus_addr[4:0];
  assign cidx = bus_addr[7:2];

  logic [NPINS-1:0] syn, lvl, evt, inv_v, cpu0_en, out_flat, stat_flat;
  logic [NPINS-1:0][CFG_W-1:0] cfg_all;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .d(pin_in), .q(syn)
  );

  // per-pin configuration and detector
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pin_cfg_t cfg_q, cfg_d;
    logic     cfg_we;

    always_comb begin
      cfg_we = bus_we && (page == CFG_PAGE_V) && (bus_addr[1:0] == 2'b00)
               && (int'(cidx) == i);
      cfg_d  = pin_cfg_t'(bus_wdata[CFG_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n)    cfg_q <= '0;
      else if (cfg_we) cfg_q <= cfg_d;
    end

    assign cfg_all[i] = cfg_q;
    assign inv_v[i]   = cfg_q.inv;
    assign cpu0_en[i] = cfg_q.route[CPU0_BIT];
    assign lvl[i]     = syn[i] ^ inv_v[i];

    gpio_pin_detect u_det (
      .clk(clk), .rst_n(rst_q_n), .lvl(lvl[i]), .trig(cfg_q.trig), .evt(evt[i])
    );
  end

  // per-bank output and status registers
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int LO = b * BANK_BITS;
    localparam int BW = (NPINS - LO > BANK_BITS) ? BANK_BITS : (NPINS - LO);
    logic          hit;
    logic [BW-1:0] out_q_b, stat_q_b;

    assign hit = bus_we && (page == '0) && (int'(bsel) == b);

    gpio_bank_regs #(.BW(BW)) u_regs (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .we_out (hit && (ofs == OFS_OUT)),
      .we_set (hit && (ofs == OFS_SET)),
      .we_clr (hit && (ofs == OFS_CLR)),
      .we_stc (hit && (ofs == OFS_STC)),
      .wdata  (bus_wdata[BW-1:0]),
      .evt    (evt[LO +: BW]),
      .out_q  (out_q_b),
      .stat_q (stat_q_b)
    );

    assign out_flat[LO +: BW]  = out_q_b;
    assign stat_flat[LO +: BW] = stat_q_b;
  end

  assign pin_out = out_flat;
  assign cpu_irq = |(stat_flat & cpu0_en);

  // read path
  logic [PADW-1:0] out_pad, lvl_pad, stat_pad;
  assign out_pad  = PADW'(out_flat);
  assign lvl_pad  = PADW'(lvl);
  assign stat_pad = PADW'(stat_flat);

  always_comb begin
    bus_rdata = '0;
    if (page == '0) begin
      for (int b = 0; b < NBANK; b++) begin
        if (int'(bsel) == b) begin
          case (ofs)
            OFS_OUT:         bus_rdata = out_pad[b*BANK_BITS +: BANK_BITS];
            OFS_IN:          bus_rdata = lvl_pad[b*BANK_BITS +: BANK_BITS];
            OFS_ST, OFS_STC: bus_rdata = stat_pad[b*BANK_BITS +: BANK_BITS];
            default:         bus_rdata = '0;
          endcase
        end
      end
    end else if (page == CFG_PAGE_V && bus_addr[1:0] == 2'b00) begin
      for (int p = 0; p < NPINS; p++) begin
        if (int'(cidx) == p) bus_rdata = {{(BANK_BITS-CFG_W){1'b0}}, cfg_all[p]};
      end
    end
  end
endmodule

// File: rtl/gpio_irq_chk.sv
`timescale 1ns/1ps
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 40,
  parameter int ADDR_W = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_we,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [BANK_BITS-1:0] bus_wdata,
  input logic [NPINS-1:0]     pin_out,
  input logic [NPINS-1:0]     stat,
  input logic [NPINS-1:0]     evt,
  input logic                 cpu_irq
);
  localparam int BW0 = (NPINS < BANK_BITS) ? NPINS : BANK_BITS;

  logic stc_wr, set0_wr, clr0_wr;
  assign stc_wr  = bus_we && (bus_addr[ADDR_W-1:8] == '0) && (bus_addr[4:0] == OFS_STC);
  assign set0_wr = bus_we && (bus_addr == ADDR_W'(OFS_SET));
  assign clr0_wr = bus_we && (bus_addr == ADDR_W'(OFS_CLR));

  // R8: a status bit only falls after a clear-mask write
  p_stat_drop_needs_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((~stat & $past(stat)) != '0) |-> $past(stc_wr));

  // R10 / R6: every event is latched, even against a clear
  p_event_latched_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat & $past(evt)) == $past(evt)));

  // R2: outputs hold without a write
  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_we) |-> $stable(pin_out));

  // R2: set-mask raises the written bits
  p_set_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set0_wr |=> ((pin_out[BW0-1:0] & $past(bus_wdata[BW0-1:0])) == $past(bus_wdata[BW0-1:0])));

  // R2: clear-mask drops the written bits
  p_clr_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr0_wr |=> ((pin_out[BW0-1:0] & $past(bus_wdata[BW0-1:0])) == '0));

  // R9: the interrupt needs a pending status bit
  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (stat != '0));
endmodule

bind gpio_irq_bank gpio_irq_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .stat(stat_flat), .evt(evt),
  .cpu_irq(cpu_irq)
);

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;
  localparam int K_REG = 0, K_IRQ = 1, K_OLO = 2, K_OHI = 3;

  logic        clk = 1'b0;
  logic        rst_n, bus_we, cpu_irq;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [39:0] pin_in, pin_out;

  always #4 clk = ~clk;   // 125 MHz

  gpio_irq_bank #(.NPINS(40), .ADDR_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .cpu_irq(cpu_irq)
  );

  typedef struct {
    int          kind;
    logic [11:0] addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int    checks = 0, errors = 0;
  bit    finished = 1'b0;

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  // driver: queue an expectation, the monitor compares it
  task automatic expect_val(input int kind, input logic [11:0] a,
                            input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
    sb.push_back(it);
    #3;
  endtask

  task automatic drive_pins(input logic [39:0] v);
    @(negedge clk); pin_in = v;
    repeat (3) @(posedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk); #2;
      while (sb.size() > 0) begin
        item_t       it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          K_REG:   act = bus_rdata;
          K_IRQ:   act = {31'b0, cpu_irq};
          K_OLO:   act = pin_out[31:0];
          default: act = {24'b0, pin_out[39:32]};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    expect_val(K_REG, 12'h000, 32'h0, "R1 out0");
    expect_val(K_REG, 12'h010, 32'h0, "R1 stat0");
    expect_val(K_REG, 12'h030, 32'h0, "R1 stat1");
    expect_val(K_REG, 12'h114, 32'h0, "R1 cfg5");
    expect_val(K_IRQ, 12'h000, 32'h0, "R1 irq");
    expect_val(K_OLO, 12'h000, 32'h0, "R1 pin_out");

    // R2 / R3 output aliases and bank mapping
    wr(12'h004, 32'h0000_00FF);
    expect_val(K_REG, 12'h000, 32'h0000_00FF, "R2 set0");
    wr(12'h008, 32'h0000_000F);
    expect_val(K_OLO, 12'h000, 32'h0000_00F0, "R2 clr0");
    wr(12'h024, 32'hFFFF_FF81);
    expect_val(K_REG, 12'h020, 32'h0000_0081, "R3 set1 width");
    expect_val(K_OHI, 12'h000, 32'h0000_0081, "R3 pin32 map");
    wr(12'h028, 32'h0000_0001);
    expect_val(K_OHI, 12'h000, 32'h0000_0080, "R3 clr1");
    wr(12'h000, 32'h1234_0000);
    expect_val(K_OLO, 12'h000, 32'h1234_0000, "R2 load0");
    wr(12'h004, 32'h0000_0005);
    expect_val(K_REG, 12'h000, 32'h1234_0005, "R2 set keeps others");

    // R4 input path, R11 inversion on input register
    drive_pins(40'hA5_1234_5678);
    expect_val(K_REG, 12'h00C, 32'h1234_5678, "R4 in0");
    expect_val(K_REG, 12'h02C, 32'h0000_00A5, "R4 in1");
    wr(12'h100, 32'h0000_0100);
    expect_val(K_REG, 12'h00C, 32'h1234_5679, "R11 inv input");
    wr(12'h100, 32'h0);
    drive_pins(40'h0);
    expect_val(K_REG, 12'h00C, 32'h0, "R4 in0 low");
    expect_val(K_REG, 12'h010, 32'h0, "R5 off no status");

    // R6 rising edge on pin 3
    wr(12'h10C, 32'h21);
    expect_val(K_REG, 12'h10C, 32'h21, "R5 cfg readback");
    drive_pins(40'h8);
    expect_val(K_REG, 12'h010, 32'h8, "R6 rise latched");
    expect_val(K_IRQ, 12'h000, 32'h1, "R9 irq on");
    drive_pins(40'h0);
    expect_val(K_REG, 12'h010, 32'h8, "R6 sticky");
    wr(12'h014, 32'h8);
    expect_val(K_REG, 12'h010, 32'h0, "R8 cleared");
    expect_val(K_IRQ, 12'h000, 32'h0, "R9 irq off");

    // R5 falling code ignores a rise
    wr(12'h10C, 32'h22);
    drive_pins(40'h8);
    expect_val(K_REG, 12'h010, 32'h0, "R5 fall ignores rise");
    drive_pins(40'h0);
    expect_val(K_REG, 12'h010, 32'h8, "R5 fall latched");

    // R3 / R5 either edge on pin 33
    wr(12'h184, 32'h23);
    drive_pins(40'h02_0000_0000);
    expect_val(K_REG, 12'h030, 32'h2, "R3 stat1 pin33");
    wr(12'h014, 32'h8);
    expect_val(K_REG, 12'h010, 32'h0, "R8 bank0 cleared");
    expect_val(K_REG, 12'h030, 32'h2, "R8 bank1 untouched");
    expect_val(K_IRQ, 12'h000, 32'h1, "R9 irq from bank1");

    // R10 falling edge of pin 33 meets a clear in the same cycle
    @(negedge clk); pin_in = 40'h0;
    @(negedge clk);
    @(negedge clk); bus_we = 1'b1; bus_addr = 12'h034; bus_wdata = 32'h2;
    @(negedge clk); bus_we = 1'b0;
    expect_val(K_REG, 12'h030, 32'h2, "R10 set wins");
    wr(12'h034, 32'h2);
    expect_val(K_REG, 12'h030, 32'h0, "R8 stat1 cleared");
    expect_val(K_IRQ, 12'h000, 32'h0, "R9 irq idle");

    // R7 high level on pin 10
    wr(12'h128, 32'h25);
    drive_pins(40'h400);
    expect_val(K_REG, 12'h010, 32'h400, "R7 high set");
    wr(12'h014, 32'h400);
    expect_val(K_REG, 12'h010, 32'h400, "R7 clear no effect");
    drive_pins(40'h0);
    expect_val(K_REG, 12'h010, 32'h400, "R7 latched after drop");
    wr(12'h014, 32'h400);
    expect_val(K_REG, 12'h010, 32'h0, "R7 clear after drop");

    // R7 low level on pin 11
    wr(12'h12C, 32'h24);
    expect_val(K_REG, 12'h010, 32'h800, "R7 low set");
    drive_pins(40'h800);
    wr(12'h014, 32'h800);
    expect_val(K_REG, 12'h010, 32'h0, "R7 low cleared");

    // R9 unrouted pin 12 latches but raises no interrupt
    wr(12'h130, 32'h01);
    drive_pins(40'h1800);
    expect_val(K_REG, 12'h010, 32'h1000, "R9 unrouted status");
    expect_val(K_IRQ, 12'h000, 32'h0, "R9 unrouted irq");
    wr(12'h014, 32'h1000);

    // R5 invalid code on pin 13
    wr(12'h134, 32'h26);
    drive_pins(40'h3800);
    drive_pins(40'h1800);
    expect_val(K_REG, 12'h010, 32'h0, "R5 invalid code");

    // R11 inversion in front of the detector, pin 14
    wr(12'h138, 32'h100);
    wr(12'h138, 32'h121);
    drive_pins(40'h5800);
    expect_val(K_REG, 12'h010, 32'h0, "R11 inverted rise ignored");
    drive_pins(40'h1800);
    expect_val(K_REG, 12'h010, 32'h4000, "R11 inverted fall latched");
    expect_val(K_IRQ, 12'h000, 32'h1, "R11 irq");

    finished = 1'b1;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule